// File: doc/BRIEF.md
# Oscillator and PLL Enable Control Registers

This block is a small register file that decides whether the main crystal oscillator, the secondary crystal oscillator and two PLLs are powered. It drives one enable line to each analog cell. A simple memory-mapped port serves the registers: address, write data, a write strobe and combinational read data. The main oscillator and PLL1 each have a pair of bits, override and enable. The software enable bit counts only while the override bit is set. While override is clear, hardware keeps that unit running. PLL2 has a plain enable bit. The secondary oscillator has a disable bit.

For each of the main oscillator and PLL1, a counter models the settle time. The read-only status bit of that unit rises a fixed number of cycles after its effective enable rises, and clears one cycle after the effective enable falls. A read-only frequency register returns the two PLL multipliers. Their values are fixed by parameters.

Top module: `osc_pll_regs`

## Requirements
- R1: After reset, the crystal register (0x0C) and the PLL register (0x10) read 0. The frequency register reads its parameter value. main_osc_en_o, sec_osc_en_o and pll1_en_o are 1, and pll2_en_o is 0.
- R2: Crystal register bit 0 is the main override and bit 1 is the main enable. main_osc_en_o equals bit 1 while bit 0 is 1, and is 1 while bit 0 is 0.
- R3: PLL register bit 0 is the PLL1 override and bit 1 is the PLL1 enable. pll1_en_o equals bit 1 while bit 0 is 1. While bit 0 is 0, pll1_en_o stays 1 whatever is written to bit 1.
- R4: PLL register bit 28 drives pll2_en_o directly, with no override.
- R5: Crystal register bit 19 set turns sec_osc_en_o off. Clear, it leaves the output on.
- R6: The status bit (bit 2 of the crystal register for the main oscillator, bit 2 of the PLL register for PLL1) reads 1 starting at the SETTLE_CYCLES-th clock edge after the effective enable rises, and not before.
- R7: A status bit reads 0 from the first clock edge after the effective enable falls.
- R8: Writes to status bits have no effect. Reserved bits read 0. Unmapped addresses read 0.
- R9: The frequency register (0x14) holds the PLL1 multiplier in bits [13:8] and the PLL2 multiplier in bits [29:24]. Writes to it are ignored.
- R10: Crystal register bit 20 and PLL register bit 29 are timer enables that store and read back the written value.
- R11: Writing override 0 with enable 1 to the crystal register keeps a running main oscillator running with its status held. Writing override 1 with enable 0 turns it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, deasserted in step with clk |
| addr_i | input | ADDR_W | Byte address of the register |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| main_osc_en_o | output | 1 | Enable to the main crystal oscillator |
| sec_osc_en_o | output | 1 | Enable to the secondary crystal oscillator |
| pll1_en_o | output | 1 | Enable to PLL1 |
| pll2_en_o | output | 1 | Enable to PLL2 |

## Verification
The assertions assume that addr_i, wr_en_i and wdata_i are known and stable around each rising edge. They also assume that reset deasserts on a clock-aligned boundary, so the first edge after reset starts the settle count. The bench changes inputs only on falling edges, deasserts reset at a falling edge, and holds the write strobe for exactly one rising edge per access. As a result, every write in the assertions lands on a single known edge.

// File: rtl/osc_pll_pkg.sv
package osc_pll_pkg;
  localparam int REG_W = 32;
  localparam int XTAL_OFS = 12;
  localparam int PLL_OFS  = 16;
  localparam int FREQ_OFS = 20;

  // bit positions shared by both control registers
  localparam int B_OVR  = 0;
  localparam int B_EN   = 1;
  localparam int B_STAT = 2;
  // crystal register
  localparam int B_SEC_DIS = 19;
  localparam int B_XTMR    = 20;
  // PLL register
  localparam int B_PLL2 = 28;
  localparam int B_PTMR = 29;
  // frequency register
  localparam int MUL_W   = 6;
  localparam int B_MUL1  = 8;
  localparam int B_MUL2  = 24;

  localparam int NUM_SETTLE = 2;  // main oscillator, PLL1

  typedef struct packed {
    logic tmr_en;
    logic sec_dis;
    logic ovr;
    logic en;
  } xtal_ctrl_t;

  typedef struct packed {
    logic tmr_en;
    logic pll2_en;
    logic ovr;
    logic en;
  } pll_ctrl_t;
endpackage

// File: rtl/osc_pll_regfile.sv
module osc_pll_regfile
  import osc_pll_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output xtal_ctrl_t        xtal_o,
  output pll_ctrl_t         pll_o
);
  logic       hit_xtal, hit_pll;
  logic       xtal_ce, pll_ce;
  xtal_ctrl_t xtal_d, xtal_q;
  pll_ctrl_t  pll_d, pll_q;

  assign hit_xtal = (addr_i == ADDR_W'(XTAL_OFS));
  assign hit_pll  = (addr_i == ADDR_W'(PLL_OFS));
  assign xtal_ce  = wr_en_i && hit_xtal;
  assign pll_ce   = wr_en_i && hit_pll;

  // next-state: only writable fields are captured, status bits are dropped
  always_comb begin
    xtal_d.ovr     = wdata_i[B_OVR];
    xtal_d.en      = wdata_i[B_EN];
    xtal_d.sec_dis = wdata_i[B_SEC_DIS];
    xtal_d.tmr_en  = wdata_i[B_XTMR];
    pll_d.ovr      = wdata_i[B_OVR];
    pll_d.en       = wdata_i[B_EN];
    pll_d.pll2_en  = wdata_i[B_PLL2];
    pll_d.tmr_en   = wdata_i[B_PTMR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xtal_q <= '0;
    end else if (xtal_ce) begin
      xtal_q <= xtal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_q <= '0;
    end else if (pll_ce) begin
      pll_q <= pll_d;
    end
  end

  assign xtal_o = xtal_q;
  assign pll_o  = pll_q;

  AST_PLL_WR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    pll_ce |=> (pll_o.pll2_en == $past(wdata_i[B_PLL2])))
    else $error("pll2 enable not captured"); // R4

  AST_XTAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i || !hit_xtal) |=> $stable(xtal_o))
    else $error("crystal register changed without write"); // R10
endmodule

// File: rtl/osc_settle_tracker.sv
module osc_settle_tracker #(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic status_o
);
  localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stat_q, stat_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    stat_d = stat_q;
    if (!en_i) begin
      cnt_d  = '0;
      stat_d = 1'b0;
    end else if (at_last) begin
      stat_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;

  AST_STATUS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !status_o)
    else $error("status outlived enable"); // R7

  AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && status_o) |=> status_o)
    else $error("status dropped while enabled"); // R6

  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o) |-> $past(en_i))
    else $error("status rose without enable"); // R6
endmodule

// File: rtl/osc_pll_regs.sv
module osc_pll_regs
  import osc_pll_pkg::*;
#(
  parameter int             ADDR_W        = 8,
  parameter int             SETTLE_CYCLES = 64,
  parameter logic [MUL_W-1:0] PLL1_MUL    = 6'h1A,
  parameter logic [MUL_W-1:0] PLL2_MUL    = 6'h0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              main_osc_en_o,
  output logic              sec_osc_en_o,
  output logic              pll1_en_o,
  output logic              pll2_en_o
);
  localparam logic [REG_W-1:0] FREQ_VAL =
    (REG_W'(PLL2_MUL) << B_MUL2) | (REG_W'(PLL1_MUL) << B_MUL1);
  localparam logic [REG_W-1:0] XTAL_RMASK =
    (REG_W'(1) << B_OVR) | (REG_W'(1) << B_EN) | (REG_W'(1) << B_STAT) |
    (REG_W'(1) << B_SEC_DIS) | (REG_W'(1) << B_XTMR);

  xtal_ctrl_t            xtal;
  pll_ctrl_t             pll;
  logic [NUM_SETTLE-1:0] eff_en;
  logic [NUM_SETTLE-1:0] status;
  logic                  main_eff, pll1_eff;

  osc_pll_regfile #(.ADDR_W(ADDR_W)) u_regfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .xtal_o  (xtal),
    .pll_o   (pll)
  );

  // software enable counts only under override; otherwise hardware keeps it on
  assign main_eff = xtal.ovr ? xtal.en : 1'b1;
  assign pll1_eff = pll.ovr  ? pll.en  : 1'b1;
  assign eff_en   = {pll1_eff, main_eff};

  for (genvar g = 0; g < NUM_SETTLE; g++) begin : g_settle
    osc_settle_tracker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (eff_en[g]),
      .status_o (status[g])
    );
  end

  assign main_osc_en_o = main_eff;
  assign pll1_en_o     = pll1_eff;
  assign sec_osc_en_o  = ~xtal.sec_dis;
  assign pll2_en_o     = pll.pll2_en;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(XTAL_OFS)) begin
      rdata_o[B_OVR]     = xtal.ovr;
      rdata_o[B_EN]      = xtal.en;
      rdata_o[B_STAT]    = status[0];
      rdata_o[B_SEC_DIS] = xtal.sec_dis;
      rdata_o[B_XTMR]    = xtal.tmr_en;
    end else if (addr_i == ADDR_W'(PLL_OFS)) begin
      rdata_o[B_OVR]  = pll.ovr;
      rdata_o[B_EN]   = pll.en;
      rdata_o[B_STAT] = status[1];
      rdata_o[B_PLL2] = pll.pll2_en;
      rdata_o[B_PTMR] = pll.tmr_en;
    end else if (addr_i == ADDR_W'(FREQ_OFS)) begin
      rdata_o = FREQ_VAL;
    end
  end

  AST_PLL1_HW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(PLL_OFS) && !wdata_i[B_OVR]) |=> pll1_en_o)
    else $error("PLL1 not held on without override"); // R3

  AST_MAIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(XTAL_OFS) && wdata_i[B_OVR] && !wdata_i[B_EN])
      |=> !main_osc_en_o)
    else $error("main oscillator not turned off"); // R11

  AST_MAIN_HW_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(XTAL_OFS) && !wdata_i[B_OVR]) |=> main_osc_en_o)
    else $error("main oscillator not held on"); // R2

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(XTAL_OFS)) |-> ((rdata_o & ~XTAL_RMASK) == '0))
    else $error("reserved crystal bits nonzero"); // R8
endmodule

// File: tb/test_osc_pll_regs.sv
module test_osc_pll_regs;
  localparam int SETTLE = 64;
  localparam logic [7:0] A_XTAL = 8'h0C;
  localparam logic [7:0] A_PLL  = 8'h10;
  localparam logic [7:0] A_FREQ = 8'h14;
  localparam logic [31:0] M_XTAL = 32'h0018_0003;  // bits 20,19,1,0
  localparam logic [31:0] M_PLL  = 32'h3000_0003;  // bits 29,28,1,0
  localparam logic [31:0] FREQ_EXP = 32'h1100_2B00; // mul2=0x11 [29:24], mul1=0x2B [13:8]
  localparam int NV = 11;
  // {sel(0=crystal,1=pll), wdata, expected {main,sec,pll1,pll2}}
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 32'h0000_0003, 4'b1110},
    {1'b0, 32'h0000_0001, 4'b0110},
    {1'b0, 32'h0008_0002, 4'b1010},
    {1'b0, 32'h0000_0000, 4'b1110},
    {1'b1, 32'h0000_0002, 4'b1110},
    {1'b1, 32'h0000_0001, 4'b1100},
    {1'b1, 32'h1000_0003, 4'b1111},
    {1'b1, 32'h3000_0000, 4'b1111},
    {1'b1, 32'h0000_0000, 4'b1110},
    {1'b0, 32'hFFFF_FFFF, 4'b1010},
    {1'b0, 32'h0000_0000, 4'b1110}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        main_en, sec_en, p1_en, p2_en;
  int          n_chk = 0;
  int          n_err = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  osc_pll_regs #(.ADDR_W(8), .SETTLE_CYCLES(SETTLE),
                 .PLL1_MUL(6'h2B), .PLL2_MUL(6'h11)) i_osc_pll_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .main_osc_en_o(main_en), .sec_osc_en_o(sec_en),
    .pll1_en_o(p1_en), .pll2_en_o(p2_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(A_XTAL, r); chk("R1 crystal reg", r, 32'h0);
    rd_reg(A_PLL, r);  chk("R1 pll reg", r, 32'h0);
    rd_reg(A_FREQ, r); chk("R1 freq reg", r, FREQ_EXP);
    chk("R1 enables", {28'h0, main_en, sec_en, p1_en, p2_en}, 32'hE);

    // R2 R3 R4 R5 R10 vector table
    for (int i = 0; i < NV; i++) begin
      logic [7:0]  a;
      logic [31:0] m;
      a = VEC[i][36] ? A_PLL : A_XTAL;
      m = VEC[i][36] ? M_PLL : M_XTAL;
      wr_reg(a, VEC[i][35:4]);
      chk($sformatf("R2/R3/R4/R5 vector %0d enables", i),
          {28'h0, main_en, sec_en, p1_en, p2_en}, {28'h0, VEC[i][3:0]});
      rd_reg(a, r);
      chk($sformatf("R10/R8 vector %0d readback", i), r & ~32'h4, VEC[i][35:4] & m);
    end

    // R9 frequency register ignores writes
    wr_reg(A_FREQ, 32'hFFFF_FFFF);
    rd_reg(A_FREQ, r); chk("R9 freq after write", r, FREQ_EXP);
    // R8 unmapped reads zero
    rd_reg(8'h18, r); chk("R8 unmapped read", r, 32'h0);

    // R6 R7 main oscillator status timing
    wr_reg(A_XTAL, 32'h1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd_reg(A_XTAL, r); chk("R7 status off", r[2], 1'b0);
    // R8 status write ignored
    wr_reg(A_XTAL, 32'h5);
    rd_reg(A_XTAL, r); chk("R8 status write ignored", r, 32'h1);
    wr_reg(A_XTAL, 32'h3);
    repeat (SETTLE - 1) @(posedge clk);
    @(negedge clk);
    rd_reg(A_XTAL, r); chk("R6 status before settle", r[2], 1'b0);
    @(posedge clk); @(negedge clk);
    rd_reg(A_XTAL, r); chk("R6 status at settle", r[2], 1'b1);
    // R11 override 0 with enable 1 keeps it running
    wr_reg(A_XTAL, 32'h2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_reg(A_XTAL, r); chk("R11 stays running", {main_en, r[2]}, 2'b11);
    wr_reg(A_XTAL, 32'h1);
    rd_reg(A_XTAL, r); chk("R7 status one cycle lag", {main_en, r[2]}, 2'b01);
    @(posedge clk); @(negedge clk);
    rd_reg(A_XTAL, r); chk("R7 status cleared", r[2], 1'b0);
    chk("R11 off with override", main_en, 1'b0);

    // R6 R7 PLL1 status
    wr_reg(A_PLL, 32'h1);
    @(posedge clk); @(negedge clk);
    rd_reg(A_PLL, r); chk("R7 pll1 status off", r[2], 1'b0);
    wr_reg(A_PLL, 32'h2);
    repeat (SETTLE - 1) @(posedge clk);
    @(negedge clk);
    rd_reg(A_PLL, r); chk("R6 pll1 before settle", r[2], 1'b0);
    @(posedge clk); @(negedge clk);
    rd_reg(A_PLL, r); chk("R6 pll1 at settle", r, 32'h6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule